// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog Timer

This block is a watchdog for a host processor. A prescaler turns the system clock into slow ticks, and each tick lowers a down-counter. Host software must keep reloading the counter before it runs out. When the counter runs out the first time, the block raises a timeout flag and starts counting again from the programmed start value. If the counter runs out a second time while that flag is still raised, the block raises a second-timeout flag, stops counting and emits a one-cycle system reset pulse. A separate lock bit can hold the reset back. When the lock bit is set, the second expiry still raises the second-timeout flag.

The host sees a 32-byte window of 16-bit registers. Register offsets are 0x00 for count and reload, 0x02 for the start value, 0x04 for control, 0x06 for status and 0x08 for the no-reboot lock. Writes take effect on the clock edge that samples `bus_wr`. Reads come back combinationally from `bus_addr`. The reset input is asynchronous and active low. It is released to the logic through a two-stage synchronizer.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the count (0x00) and the start value (0x02) both read INIT_DEFAULT. Control reads 0x0001, which means halted. Status reads 0x0004, which means only the boot flag is set. The lock register reads 0x0001. `sys_reset_pulse` is 0.
- R2: While control bit 0 (halt) is 1, the count does not change. While it is 0 and the counter has not stopped, the counter runs.
- R3: While running, the count decreases by one every TICK_CYCLES clock cycles. Offset 0x00 returns the count in bits [9:0] and zero above them.
- R4: A write of any value to offset 0x00 loads the count from the start value, restarts the prescaler from zero and clears the stopped state.
- R5: Offset 0x02 holds the start value in bits [9:0]. Bits [15:10] are stored as written and read back as stored. A write whose bits [9:0] are below 4 is ignored entirely.
- R6: The tick that would take the count below 1 is an expiry. At that tick the count reloads from the start value, so the count never reads 0. When status bit 0 (first timeout) is clear, an expiry sets it. The first expiry therefore comes start-value ticks after a reload.
- R7: An expiry while status bit 0 is set is a second expiry. It sets status bit 1 (second timeout) and stops the counter until a write to 0x00. If lock bit 0 is 0, it also drives `sys_reset_pulse` high for exactly one cycle.
- R8: When lock bit 0 (offset 0x08) is 1, a second expiry gives no reset pulse but still sets status bit 1. The lock bit reads back as written.
- R9: Status bits 0, 1 and 2 (boot) are each cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R10: Whether an expiry is the first or the second is decided from status bit 0 as it stood before a write in the same cycle. On a given bit, a set in a cycle wins over a clear in that cycle.
- R11: Reads of odd offsets and of 0x0A to 0x1F return zero. Writes to those offsets change nothing.
- R12: A write to 0x00 in the same cycle as the tick that would expire takes priority, and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset into the register window |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| sys_reset_pulse | output | 1 | One-cycle system reset request |

## Verification
Two things can land on the same clock edge: a write-one-to-clear of the first-timeout bit and a counter expiry. The bench works out exactly which cycle holds the expiring tick. It then issues the clear so that it is sampled on that edge, once with the flag already set and once with it clear.

- With the flag already set, the expiry must still count as the second one. The bench expects the second-timeout bit set, the first-timeout bit cleared and a reset pulse.
- With the flag clear, the set must win and the flag must read 1.

A reload issued on the same expiring edge is judged in the same way. The bench expects no flag and a full fresh countdown afterwards.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_INIT  = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 5'h08;

  typedef struct packed {
    logic boot;
    logic to2;
    logic to1;
  } stat_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          pre_en;

  // A tick is the cycle where the prescaler sits at its last value.
  assign tick = run & ~restart & (pre_q == LAST);

  always_comb begin
    pre_en = restart | run;
    if (restart || tick) pre_d = '0;
    else                 pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned INIT_DEFAULT = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // The tick that would take the count below 1 expires and reloads instead.
  assign expire = tick & ~reload & (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_en = reload | tick;
    if (reload || expire) cnt_d = init_val;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(INIT_DEFAULT);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned INIT_DEFAULT = 50,
  parameter int unsigned MIN_INIT     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic              reload,
  output logic              halt,
  output logic              stopped,
  output logic              lock,
  output logic              to2_flag,
  output logic [CNT_W-1:0]  init_val,
  output logic              reset_pulse
);
  // Write decode
  logic wr_init, wr_ctrl, wr_stat, wr_lock, init_ok;
  logic [2:0] clr;

  assign reload  = bus_wr & (bus_addr == OFS_COUNT);
  assign wr_init = bus_wr & (bus_addr == OFS_INIT);
  assign wr_ctrl = bus_wr & (bus_addr == OFS_CTRL);
  assign wr_stat = bus_wr & (bus_addr == OFS_STAT);
  assign wr_lock = bus_wr & (bus_addr == OFS_LOCK);
  assign init_ok = bus_wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT);
  assign clr     = wr_stat ? bus_wdata[2:0] : 3'b000;

  // State
  logic [DATA_W-1:0] init_q;
  logic              halt_q, lock_q, stop_q, stop_d, pulse_q, pulse_d;
  stat_t             stat_q, stat_d;
  logic              first_exp, second_exp, init_en;

  // Classification uses the flag before any same-cycle write.
  assign first_exp  = expire & ~stat_q.to1;
  assign second_exp = expire &  stat_q.to1;
  assign init_en    = wr_init & init_ok;

  always_comb begin
    stat_d.to1  = (stat_q.to1  & ~clr[0]) | first_exp;
    stat_d.to2  = (stat_q.to2  & ~clr[1]) | second_exp;
    stat_d.boot =  stat_q.boot & ~clr[2];
    pulse_d     = second_exp & ~lock_q;
    if (reload) stop_d = 1'b0;
    else        stop_d = stop_q | second_exp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       init_q <= DATA_W'(INIT_DEFAULT);
    else if (init_en) init_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       halt_q <= 1'b1;
    else if (wr_ctrl) halt_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b1;
    else if (wr_lock) lock_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '{boot: 1'b1, to2: 1'b0, to1: 1'b0};
      stop_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      stop_q  <= stop_d;
      pulse_q <= pulse_d;
    end
  end

  // Read mux
  always_comb begin
    unique case (bus_addr)
      OFS_COUNT: bus_rdata = DATA_W'(count);
      OFS_INIT:  bus_rdata = init_q;
      OFS_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, halt_q};
      OFS_STAT:  bus_rdata = {{(DATA_W-3){1'b0}}, stat_q};
      OFS_LOCK:  bus_rdata = {{(DATA_W-1){1'b0}}, lock_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign halt        = halt_q;
  assign stopped     = stop_q;
  assign lock        = lock_q;
  assign to2_flag    = stat_q.to2;
  assign init_val    = init_q[CNT_W-1:0];
  assign reset_pulse = pulse_q;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned TICK_CYCLES  = 30_000_000,
  parameter int unsigned INIT_DEFAULT = 50,
  parameter int unsigned MIN_INIT     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sys_reset_pulse
);
  logic             rst_sync_n;
  logic             tick_w, run_w, reload_w, halt_w, stop_w, lock_w, to2_w, exp_w;
  logic [CNT_W-1:0] count_w, init_w;

  wdt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign run_w = ~halt_w & ~stop_w;

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run_w),
    .restart (reload_w),
    .tick    (tick_w)
  );

  wdt_counter #(.CNT_W(CNT_W), .INIT_DEFAULT(INIT_DEFAULT)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick_w),
    .reload   (reload_w),
    .init_val (init_w),
    .count    (count_w),
    .expire   (exp_w)
  );

  wdt_regs #(.CNT_W(CNT_W), .INIT_DEFAULT(INIT_DEFAULT), .MIN_INIT(MIN_INIT)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .count       (count_w),
    .expire      (exp_w),
    .reload      (reload_w),
    .halt        (halt_w),
    .stopped     (stop_w),
    .lock        (lock_w),
    .to2_flag    (to2_w),
    .init_val    (init_w),
    .reset_pulse (sys_reset_pulse)
  );
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MIN_INIT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_reset_pulse,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] init_val,
  input logic             halt,
  input logic             reload,
  input logic             lock,
  input logic             to2
);
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_pulse |=> !sys_reset_pulse);

  // R7
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_pulse |-> to2);

  // R8
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_pulse |-> !$past(lock));

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload) |=> (count == $past(count)));

  // R6
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count != '0);

  // R5
  init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_val >= CNT_W'(MIN_INIT));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .sys_reset_pulse (sys_reset_pulse),
  .count           (count_w),
  .init_val        (init_w),
  .halt            (halt_w),
  .reload          (reload_w),
  .lock            (lock_w),
  .to2             (to2_w)
);

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
  localparam int T     = 4;
  localparam int INIT0 = 6;
  localparam int IT    = T * INIT0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        sys_reset_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wdt_two_stage #(.CNT_W(10), .TICK_CYCLES(T), .INIT_DEFAULT(INIT0), .MIN_INIT(4)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .sys_reset_pulse (sys_reset_pulse)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic [4:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pchk(input string req, input logic exp);
    chk(req, {15'b0, sys_reset_pulse}, {15'b0, exp});
  endtask

  // Called at a falling edge; the write is sampled on the next rising edge.
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reload, then follow the count through a full countdown to the first expiry.
  task automatic sweep(input int init, input logic [15:0] stat_after);
    wr(5'h00, 16'h0000);
    for (int m = 0; m < init * T; m++) begin
      rdchk("R3 count", 5'h00, 16'(init - m / T));
      idle(1);
    end
    rdchk("R6 first expiry", 5'h06, stat_after);
    rdchk("R6 reloaded", 5'h00, 16'(init));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] init_model;
    logic [15:0] v;
    logic [15:0] exp;
    rst_n     = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = 5'h00;
    bus_wdata = 16'h0000;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rdchk("R1 count", 5'h00, 16'(INIT0));
    rdchk("R1 init",  5'h02, 16'(INIT0));
    rdchk("R1 ctrl",  5'h04, 16'h0001);
    rdchk("R1 stat",  5'h06, 16'h0004);
    rdchk("R1 lock",  5'h08, 16'h0001);
    pchk("R1 pulse", 1'b0);

    // R2 halted after reset
    idle(10);
    rdchk("R2 halted count", 5'h00, 16'(INIT0));

    // R3/R4/R6 countdown with lock set
    wr(5'h04, 16'h0000);
    sweep(INIT0, 16'h0005);

    // R8 second expiry with lock set
    idle(IT - 1);
    rdchk("R7 before second", 5'h06, 16'h0005);
    idle(1);
    rdchk("R8 second flag", 5'h06, 16'h0007);
    pchk("R8 no pulse", 1'b0);
    idle(10);
    rdchk("R7 stopped", 5'h00, 16'(INIT0));
    rdchk("R8 lock readback", 5'h08, 16'h0001);

    // R9 write-one-to-clear
    wr(5'h06, 16'h0000);
    rdchk("R9 zero write", 5'h06, 16'h0007);
    wr(5'h06, 16'h0002);
    rdchk("R9 clear bit1", 5'h06, 16'h0005);
    wr(5'h06, 16'h0001);
    rdchk("R9 clear bit0", 5'h06, 16'h0004);
    wr(5'h06, 16'h0004);
    rdchk("R9 clear boot", 5'h06, 16'h0000);

    // R7 second expiry with lock clear
    wr(5'h08, 16'h0000);
    rdchk("R8 lock cleared", 5'h08, 16'h0000);
    wr(5'h00, 16'h0000);
    idle(IT);
    rdchk("R6 first", 5'h06, 16'h0001);
    idle(IT - 1);
    pchk("R7 pulse early", 1'b0);
    idle(1);
    pchk("R7 pulse", 1'b1);
    rdchk("R7 second flag", 5'h06, 16'h0003);
    idle(1);
    pchk("R7 pulse one cycle", 1'b0);
    idle(8);
    rdchk("R7 stopped count", 5'h00, 16'(INIT0));
    pchk("R7 no repeat", 1'b0);
    wr(5'h06, 16'h0003);

    // R10 clear of bit0 on the second-expiry edge
    wr(5'h00, 16'h0000);
    idle(IT);
    rdchk("R10 first", 5'h06, 16'h0001);
    idle(IT - 1);
    wr(5'h06, 16'h0001);
    rdchk("R10 second despite clear", 5'h06, 16'h0002);
    pchk("R10 pulse", 1'b1);
    wr(5'h06, 16'h0002);

    // R10 clear of bit0 on the first-expiry edge: set wins
    wr(5'h00, 16'h0000);
    idle(IT - 1);
    wr(5'h06, 16'h0001);
    rdchk("R10 set wins", 5'h06, 16'h0001);
    wr(5'h06, 16'h0001);
    rdchk("R9 cleared", 5'h06, 16'h0000);

    // R12 reload on the expiring edge
    wr(5'h00, 16'h0000);
    idle(IT - 1);
    wr(5'h00, 16'h0000);
    rdchk("R12 no expiry", 5'h06, 16'h0000);
    rdchk("R12 count", 5'h00, 16'(INIT0));
    idle(IT - 1);
    rdchk("R12 full restart", 5'h06, 16'h0000);
    idle(1);
    rdchk("R12 expiry later", 5'h06, 16'h0001);
    wr(5'h06, 16'h0001);

    // R2 halt while running
    wr(5'h00, 16'h0000);
    idle(5);
    wr(5'h04, 16'h0001);
    rdchk("R2 halt", 5'h00, 16'(INIT0 - 1));
    idle(12);
    rdchk("R2 hold", 5'h00, 16'(INIT0 - 1));

    // R5 start-value sweep
    init_model = 16'(INIT0);
    for (int i = 0; i < 16; i++) begin
      v = {6'(i) ^ 6'h2A, 10'(i)};
      wr(5'h02, v);
      if (i >= 4) init_model = v;
      rdchk("R5 init", 5'h02, init_model);
    end
    wr(5'h02, 16'hFFFF);
    rdchk("R5 max", 5'h02, 16'hFFFF);
    wr(5'h02, 16'h0003);
    rdchk("R5 reject", 5'h02, 16'hFFFF);
    wr(5'h02, 16'h5405);
    rdchk("R5 upper kept", 5'h02, 16'h5405);
    wr(5'h00, 16'h1234);
    rdchk("R4 reload", 5'h00, 16'h0005);

    // R11 address sweep
    for (int a = 0; a < 32; a++) begin
      case (a)
        0:       exp = 16'h0005;
        2:       exp = 16'h5405;
        4:       exp = 16'h0001;
        default: exp = 16'h0000;
      endcase
      rdchk("R11 read", 5'(a), exp);
    end
    for (int a = 0; a < 32; a++) begin
      if (a != 0 && a != 2 && a != 4 && a != 6 && a != 8) wr(5'(a), 16'hFFFF);
    end
    rdchk("R11 count kept", 5'h00, 16'h0005);
    rdchk("R11 init kept",  5'h02, 16'h5405);
    rdchk("R11 ctrl kept",  5'h04, 16'h0001);
    rdchk("R11 stat kept",  5'h06, 16'h0000);
    rdchk("R11 lock kept",  5'h08, 16'h0000);
    pchk("R11 no pulse", 1'b0);

    // R3 countdown from another start value
    wr(5'h04, 16'h0000);
    sweep(5, 16'h0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule